// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a small bank of configuration and status words reached over a four-wire serial port. An external host lowers chip select and exchanges one 16-bit word with the block. The host drives data on the rising edge of the serial clock, and the block samples it on the falling edge. The first bit sent selects read or write. The next four bits carry an address. The last eleven bits carry the data to write. While the frame runs, the block shifts back the 11-bit contents of the addressed word, most significant bit first. Five leading filler bits come before the contents, so the host sees the old value of a word even when it is overwriting it.

The serial pins are oversampled on a fast system clock through two-stage synchronizers, and every edge is found from the synchronized copies. A write is applied only when chip select rises after exactly sixteen falling clock edges. It is also refused if chip select rested high for less than a programmable number of system clocks before the frame began. Any refused frame sets a sticky error flag. Words 0 and 1 reflect two parallel fault input buses. Words 2 to 7 are writable control words. A three-bit field at the top of word 3 works as a write lock for the control words.

Top module: `scs_slave`

## Requirements
- R1: A frame whose bit 15 (first sent) is 0 is a write: bits 14..11 are the address and bits 10..0 the data. When unlocked, it loads an address in 2..7 at the end of the frame. A frame with bit 15 = 1 is a read of the word at that address.
- R2: SDI is sampled on falling SCLK edges. SDO changes only after rising SCLK edges. The first five response bits (15..11) are driven 0, and bits 10..0 carry the addressed word, most significant bit first.
- R3: A write frame returns on SDO the contents the addressed word held before that write.
- R4: While cs_n is high, sdo_oe and sdo are low, and SCLK and SDI activity changes no stored word.
- R5: A frame with other than 16 falling SCLK edges between cs_n falling and rising is discarded without any write, and it sets frame_err.
- R6: Address 0 reads flt_a and address 1 reads flt_b, as sampled when the address is complete. Writes to both addresses have no effect.
- R7: Addresses 8..15 read as zero, and writes to them are dropped.
- R8: Word 3 bits 10..8 form the lock field. Writing code 6 locks and writing code 3 unlocks. While locked, writes to words 2 and 4..7 and to word 3 bits 7..0 are dropped.
- R9: A lock-field code other than 6 or 3 leaves the lock field and the lock state unchanged. The other bits of word 3 follow the normal lock rule.
- R10: A frame that begins after cs_n has been high for fewer than MIN_CS_HIGH system clocks (default 100, i.e. 400 ns at 250 MHz) is discarded as a framing error.
- R11: After reset, words 2 and 4..7 read 0, word 3 reads 0x300 (unlocked), sdo_oe is low and frame_err is low.
- R12: frame_err stays set through later valid frames until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| flt_a | input | 11 | Fault bits shown at address 0 |
| flt_b | input | 11 | Fault bits shown at address 1 |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume the host keeps SCLK low across both chip-select edges. They also assume each SCLK half period lasts several system clocks, so every serial edge passes the synchronizers before the next one. The lock-state checks assume that the command word stays stable from the end of a frame until the write pulse it produces. The bench drives SCLK with half periods of eight system clocks and changes cs_n only while SCLK is low. It samples SDO just before each falling edge, and it lets chip select rest high longer than the minimum time, except in the scenario that deliberately shortens it.

// File: rtl/scs_pkg.sv
package scs_pkg;
  localparam int DATA_W    = 11;
  localparam int ADDR_W    = 4;
  localparam int FRAME_W   = 1 + ADDR_W + DATA_W;
  localparam int NUM_REGS  = 8;
  localparam int FIRST_CTL = 2;
  localparam int LOCK_REG  = 3;
  localparam int LOCK_HI   = DATA_W - 1;
  localparam int LOCK_LO   = DATA_W - 3;
  localparam logic [2:0] LOCK_ON  = 3'd6;
  localparam logic [2:0] LOCK_OFF = 3'd3;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
      else        chain_q <= chain_d;
    end

    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/scs_frame.sv
module scs_frame
  import scs_pkg::*;
#(
  parameter int MIN_CS_HIGH = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              commit,
  output logic              bad_frame,
  output cmd_t              cmd,
  output logic              frame_err
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] HDR      = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(ADDR_W);
  localparam int HI_W = $clog2(MIN_CS_HIGH + 1);
  localparam logic [HI_W-1:0] HI_MAX = HI_W'(MIN_CS_HIGH);

  logic               cs_prev_q, cs_prev_d;
  logic               sck_prev_q, sck_prev_d;
  logic               in_frame_q, in_frame_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   fcnt_q, fcnt_d;
  logic [CNT_W-1:0]   rcnt_q, rcnt_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic               early_q, early_d;
  logic               load_q, load_d;
  logic [DATA_W-1:0]  resp_q, resp_d;
  logic               sdo_q, sdo_d;
  logic               oe_q, oe_d;
  logic               commit_q, commit_d;
  logic               bad_q, bad_d;
  logic               err_q, err_d;

  logic cs_fall, cs_rise, sck_fall, sck_rise;

  assign cs_fall  = cs_prev_q & ~cs_s & ~in_frame_q;
  assign cs_rise  = ~cs_prev_q & cs_s & in_frame_q;
  assign sck_fall = sck_prev_q & ~sck_s;
  assign sck_rise = ~sck_prev_q & sck_s;

  always_comb begin
    cs_prev_d  = cs_s;
    sck_prev_d = sck_s;
    in_frame_d = in_frame_q;
    sr_d       = sr_q;
    fcnt_d     = fcnt_q;
    rcnt_d     = rcnt_q;
    hi_d       = hi_q;
    early_d    = early_q;
    load_d     = 1'b0;
    resp_d     = resp_q;
    sdo_d      = sdo_q;
    oe_d       = oe_q;
    commit_d   = 1'b0;
    bad_d      = 1'b0;
    err_d      = err_q;

    if (!in_frame_q && hi_q < HI_MAX) hi_d = hi_q + 1'b1;

    if (cs_fall) begin
      in_frame_d = 1'b1;
      fcnt_d     = '0;
      rcnt_d     = '0;
      early_d    = (hi_q < HI_MAX);
      oe_d       = 1'b1;
      sdo_d      = 1'b0;
      resp_d     = '0;
    end else if (cs_rise) begin
      in_frame_d = 1'b0;
      oe_d       = 1'b0;
      sdo_d      = 1'b0;
      hi_d       = '0;
      if (fcnt_q == CNT_FULL && !early_q) begin
        commit_d = 1'b1;
      end else begin
        bad_d = 1'b1;
        err_d = 1'b1;
      end
    end else if (in_frame_q) begin
      if (load_q) resp_d = rd_data;
      if (sck_fall) begin
        sr_d = {sr_q[FRAME_W-2:0], sdi_s};
        if (fcnt_q != CNT_MAX) fcnt_d = fcnt_q + 1'b1;
        if (fcnt_q == HDR_LAST) load_d = 1'b1;
      end
      if (sck_rise) begin
        if (rcnt_q != CNT_MAX) rcnt_d = rcnt_q + 1'b1;
        if (rcnt_q >= HDR) begin
          sdo_d  = resp_q[DATA_W-1];
          resp_d = {resp_q[DATA_W-2:0], 1'b0};
        end else begin
          sdo_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
      in_frame_q <= 1'b0;
      sr_q       <= '0;
      fcnt_q     <= '0;
      rcnt_q     <= '0;
      hi_q       <= HI_MAX;
      early_q    <= 1'b0;
      load_q     <= 1'b0;
      resp_q     <= '0;
      sdo_q      <= 1'b0;
      oe_q       <= 1'b0;
      commit_q   <= 1'b0;
      bad_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      cs_prev_q  <= cs_prev_d;
      sck_prev_q <= sck_prev_d;
      in_frame_q <= in_frame_d;
      sr_q       <= sr_d;
      fcnt_q     <= fcnt_d;
      rcnt_q     <= rcnt_d;
      hi_q       <= hi_d;
      early_q    <= early_d;
      load_q     <= load_d;
      resp_q     <= resp_d;
      sdo_q      <= sdo_d;
      oe_q       <= oe_d;
      commit_q   <= commit_d;
      bad_q      <= bad_d;
      err_q      <= err_d;
    end
  end

  assign rd_addr   = sr_q[ADDR_W-1:0];
  assign sdo       = sdo_q;
  assign sdo_oe    = oe_q;
  assign commit    = commit_q;
  assign bad_frame = bad_q;
  assign cmd       = cmd_t'(sr_q);
  assign frame_err = err_q;
endmodule

// File: rtl/scs_regs.sv
module scs_regs
  import scs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] flt_a,
  input  logic [DATA_W-1:0] flt_b,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] view [NUM_REGS];
  logic              wr_cmd;

  assign wr_cmd = commit & ~cmd.rd;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    if (i < FIRST_CTL) begin : g_stat
      assign view[i] = (i == 0) ? flt_a : flt_b;
    end else if (i == LOCK_REG) begin : g_lock
      logic [2:0]         fld_q, fld_d;
      logic [LOCK_LO-1:0] low_q, low_d;
      logic               hit;
      logic [2:0]         code;

      assign hit  = wr_cmd && (cmd.addr == ADDR_W'(i));
      assign code = cmd.data[LOCK_HI:LOCK_LO];

      always_comb begin
        fld_d = fld_q;
        low_d = low_q;
        if (hit && (code == LOCK_ON || code == LOCK_OFF)) fld_d = code;
        if (hit && !locked) low_d = cmd.data[LOCK_LO-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fld_q <= LOCK_OFF;
          low_q <= '0;
        end else begin
          fld_q <= fld_d;
          low_q <= low_d;
        end
      end

      assign view[i] = {fld_q, low_q};
      assign locked  = (fld_q == LOCK_ON);
    end else begin : g_ctl
      logic [DATA_W-1:0] val_q, val_d;
      logic              we;

      assign we = wr_cmd && !locked && (cmd.addr == ADDR_W'(i));

      always_comb val_d = we ? cmd.data : val_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end

      assign view[i] = val_q;
    end
  end

  assign rd_data = (rd_addr < ADDR_W'(NUM_REGS)) ? view[rd_addr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/scs_slave.sv
module scs_slave
  import scs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_CS_HIGH = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic [DATA_W-1:0] flt_a,
  input  logic [DATA_W-1:0] flt_b,
  output logic              frame_err
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic [2:0]        pin_q;
  logic              cs_s, sck_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr_w;
  logic [DATA_W-1:0] rd_data_w;
  logic              commit_w, bad_w, locked_w;
  cmd_t              cmd_w;

  // reset asserts at once, leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  scs_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d    ({cs_n, sck, sdi}),
    .q    (pin_q)
  );
  assign cs_s  = pin_q[2];
  assign sck_s = pin_q[1];
  assign sdi_s = pin_q[0];

  scs_frame #(
    .MIN_CS_HIGH(MIN_CS_HIGH)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .sdi_s    (sdi_s),
    .rd_data  (rd_data_w),
    .rd_addr  (rd_addr_w),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .commit   (commit_w),
    .bad_frame(bad_w),
    .cmd      (cmd_w),
    .frame_err(frame_err)
  );

  scs_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .commit (commit_w),
    .cmd    (cmd_w),
    .flt_a  (flt_a),
    .flt_b  (flt_b),
    .rd_addr(rd_addr_w),
    .rd_data(rd_data_w),
    .locked (locked_w)
  );
endmodule

// File: rtl/scs_slave_chk.sv
module scs_slave_chk
  import scs_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic frame_err,
  input logic commit,
  input logic bad_frame,
  input cmd_t cmd,
  input logic locked
);
  // R4
  idle_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

  // R2
  sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);

  // R5
  bad_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |-> !commit);

  // R5
  bad_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_frame |=> frame_err);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R8
  lock_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |->
      $past(commit && !cmd.rd && cmd.addr == ADDR_W'(LOCK_REG)));

  // R9
  bad_code_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cmd.rd && cmd.addr == ADDR_W'(LOCK_REG) &&
     cmd.data[LOCK_HI:LOCK_LO] != LOCK_ON &&
     cmd.data[LOCK_HI:LOCK_LO] != LOCK_OFF) |=> $stable(locked));
endmodule

bind scs_slave scs_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .sdo      (sdo),
  .sdo_oe   (sdo_oe),
  .frame_err(frame_err),
  .commit   (commit_w),
  .bad_frame(bad_w),
  .cmd      (cmd_w),
  .locked   (locked_w)
);

// File: tb/scs_slave_bench.sv
`timescale 1ns/1ps
module scs_slave_bench;
  localparam int HALF = 8;
  localparam int GAP  = 130;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, frame_err;
  logic [10:0] flt_a = 11'h4C3;
  logic [10:0] flt_b = 11'h2B5;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scs_slave u_scs_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .flt_a(flt_a), .flt_b(flt_b),
    .frame_err(frame_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, input int nbits, input int gap,
                      output logic [15:0] r);
    r = '0;
    @(negedge clk);
    cs_n = 1'b0; sck = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1;
      sdi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 16) r[15-i] = sdo;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_n = 1'b1; sdi = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] r);
    xfer({1'b1, a, 11'h000}, 16, GAP, r);
  endtask

  task automatic wr(input logic [3:0] a, input logic [10:0] d, output logic [15:0] r);
    xfer({1'b0, a, d}, 16, GAP, r);
  endtask

  task automatic t_reset_state();
    logic [15:0] r;
    chk("R11 sdo_oe", {15'h0, sdo_oe}, 16'h0);
    chk("R11 frame_err", {15'h0, frame_err}, 16'h0);
    rd(4'd3, r); chk("R11 word3", r, 16'h0300);
    rd(4'd5, r); chk("R11 word5", r, 16'h0000);
  endtask

  task automatic t_basic_rw();
    logic [15:0] r;
    wr(4'd2, 11'h5A5, r);
    rd(4'd2, r);
    chk("R2 header bits", {11'h0, r[15:11]}, 16'h0);
    chk("R1 word2", r, 16'h05A5);
    wr(4'd4, 11'h7FF, r);
    wr(4'd7, 11'h401, r);
    rd(4'd4, r); chk("R1 word4", r, 16'h07FF);
    rd(4'd7, r); chk("R2 word7 msb first", r, 16'h0401);
  endtask

  task automatic t_write_old();
    logic [15:0] r;
    wr(4'd2, 11'h123, r); chk("R3 old word2", r, 16'h05A5);
    rd(4'd2, r);          chk("R3 new word2", r, 16'h0123);
  endtask

  task automatic t_status();
    logic [15:0] r;
    rd(4'd0, r); chk("R6 flt_a", r, {5'h0, flt_a});
    rd(4'd1, r); chk("R6 flt_b", r, {5'h0, flt_b});
    wr(4'd0, 11'h000, r);
    flt_a = 11'h13C;
    rd(4'd0, r); chk("R6 write ignored", r, 16'h013C);
  endtask

  task automatic t_high_addr();
    logic [15:0] r;
    wr(4'd9, 11'h3FF, r);  chk("R7 write resp", r, 16'h0);
    rd(4'd9, r);           chk("R7 read 9", r, 16'h0);
    rd(4'd15, r);          chk("R7 read 15", r, 16'h0);
    rd(4'd2, r);           chk("R7 word2 intact", r, 16'h0123);
  endtask

  task automatic t_idle();
    logic [15:0] r;
    logic        seen_oe = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      sck = 1'b1; sdi = ~sdi;
      repeat (HALF) @(negedge clk);
      seen_oe |= sdo_oe | sdo;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    sdi = 1'b0;
    repeat (GAP) @(negedge clk);
    chk("R4 oe low idle", {15'h0, seen_oe}, 16'h0);
    rd(4'd2, r); chk("R4 word2 intact", r, 16'h0123);
  endtask

  task automatic t_lock();
    logic [15:0] r;
    wr(4'd3, 11'h6AB, r);
    rd(4'd3, r); chk("R8 lock set", r, 16'h06AB);
    wr(4'd2, 11'h111, r);
    wr(4'd6, 11'h222, r);
    rd(4'd2, r); chk("R8 word2 locked", r, 16'h0123);
    rd(4'd6, r); chk("R8 word6 locked", r, 16'h0000);
    wr(4'd3, 11'h3CD, r);
    rd(4'd3, r); chk("R8 unlock low kept", r, 16'h03AB);
    wr(4'd2, 11'h111, r);
    rd(4'd2, r); chk("R8 word2 after unlock", r, 16'h0111);
  endtask

  task automatic t_lock_bad_code();
    logic [15:0] r;
    wr(4'd3, 11'h1EE, r);
    rd(4'd3, r); chk("R9 bad code unlocked", r, 16'h03EE);
    wr(4'd3, 11'h655, r);
    wr(4'd3, 11'h04C, r);
    rd(4'd3, r); chk("R9 bad code locked", r, 16'h0655);
    wr(4'd5, 11'h0AA, r);
    rd(4'd5, r); chk("R9 still locked", r, 16'h0000);
    wr(4'd3, 11'h300, r);
  endtask

  task automatic t_min_high();
    logic [15:0] r;
    chk("R10 no err yet", {15'h0, frame_err}, 16'h0);
    xfer({1'b0, 4'd4, 11'h0F0}, 16, 40, r);
    xfer({1'b0, 4'd4, 11'h777}, 16, GAP, r);
    chk("R10 err set", {15'h0, frame_err}, 16'h1);
    rd(4'd4, r); chk("R10 word4 kept", r, 16'h00F0);
  endtask

  task automatic t_sticky();
    logic [15:0] r;
    wr(4'd2, 11'h0F1, r);
    rd(4'd2, r);
    chk("R12 good frame after err", r, 16'h00F1);
    chk("R12 err held", {15'h0, frame_err}, 16'h1);
    do_reset();
    chk("R12 err cleared", {15'h0, frame_err}, 16'h0);
  endtask

  task automatic t_length();
    logic [15:0] r;
    xfer({1'b0, 4'd2, 11'h2AA}, 15, GAP, r);
    chk("R5 short err", {15'h0, frame_err}, 16'h1);
    rd(4'd2, r); chk("R5 short no write", r, 16'h0000);
    do_reset();
    xfer({1'b0, 4'd2, 11'h2AA}, 17, GAP, r);
    chk("R5 long err", {15'h0, frame_err}, 16'h1);
    rd(4'd2, r); chk("R5 long no write", r, 16'h0000);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_basic_rw();
    t_write_old();
    t_status();
    t_high_addr();
    t_idle();
    t_lock();
    t_lock_bad_code();
    t_min_high();
    t_sticky();
    t_length();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule